// File: doc/BRIEF.md
# Byte Register File with Pointer Windows

This block is the data space of a small 8-bit controller: 128 byte locations on a 7-bit address, with one read port and one write port. Most of the upper part is plain RAM. The lower part holds a few registers the block keeps itself: two 7-bit pointers and the accumulator. A set of locations forwards to peripheral and status registers that live outside the block, reached through an external register bus. All other lower locations are reserved.

Two locations hold no storage. Each one is a window. Any read or write at a window goes to the location that the matching pointer names. The write port does more than store bytes. It can also set or clear one bit of any location in a single cycle, and it does this by reading the location, changing the bit and writing it back. Bit operations follow the windows just as byte writes do. The accumulator value is always present on an output port so that the arithmetic unit can use it.

Top module: `ptr_regfile`

## Requirements
- R1: After reset the two pointers and the accumulator are zero, so reading 01H, 03H and 05H returns 00H and `acc_o` is 00H. RAM contents are not initialised by reset.
- R2: A byte written to any address from 28H to 7FH reads back from that address in the cycle after the write.
- R3: Address 01H holds pointer P0 and address 03H holds pointer P1. Each pointer keeps only the low 7 bits of the data written to it. Reading a pointer returns bit 7 as 0.
- R4: A read or write at address 00H acts on the location that P0 names. A read or write at address 02H acts on the location that P1 names.
- R5: When a window's pointer holds 00H or 02H, a read through that window returns 00H. A write or bit operation through it changes no location and raises no external write.
- R6: Address 05H is the accumulator. A byte write or bit operation there updates `acc_o` at the next clock edge.
- R7: Reserved addresses always read 00H, and writes to them are ignored. With the default map these addresses are 04H, 06H–09H, 10H, 11H, 1AH–1FH and 24H–27H.
- R8: Addresses flagged in `EXT_MAP` go to the external bus. By default these are 0AH–0FH, 12H–19H and 20H–23H. A read drives `ext_raddr` with the address after any window redirection and returns `ext_rdata`. A write or bit operation raises `ext_we` for that cycle, with `ext_waddr` set to the address after redirection and `ext_wdata` set to the new byte.
- R9: `wr_op` selects the write action: 0 does nothing, 1 writes a byte, 2 clears bit `wr_bit`, and 3 sets bit `wr_bit`. A bit operation changes only the selected bit of the target location and takes one cycle.
- R10: A read at an address that is being written in the same cycle returns the old value. The new value is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 7 | Read address |
| rd_data | output | 8 | Read data, combinational |
| wr_op | input | 2 | Write action: 0 none, 1 byte, 2 clear bit, 3 set bit |
| wr_addr | input | 7 | Write address |
| wr_data | input | 8 | Byte to write |
| wr_bit | input | 3 | Bit index for set and clear |
| acc_o | output | 8 | Accumulator value |
| ext_raddr | output | 7 | External read address, after redirection |
| ext_rdata | input | 8 | External read data |
| ext_waddr | output | 7 | External write address, after redirection |
| ext_wcur | input | 8 | Current value at `ext_waddr`, used for bit operations |
| ext_we | output | 1 | External write strobe |
| ext_wdata | output | 8 | External write data |

## Verification
The hardest case to reach from the ports is a window whose pointer names a window. Getting there takes a pointer write that stores exactly 00H or 02H, and only after that can an access through the window show that it does nothing. A second hard case is a bit operation through a window onto a location whose value the bench already knows. The random stimulus handles both. It aims about half of all accesses at the windows and pointers, and when it writes a pointer it picks 00H or 02H often. Directed sequences first set a pointer and then read, write and bit-modify through it.

// File: rtl/ptr_regfile.sv
module ptr_regfile #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int RAM_LO = 'h28,
  parameter logic [(1<<AW)-1:0] EXT_MAP = 'h0F_03FC_FC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [1:0]        wr_op,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [$clog2(DW)-1:0] wr_bit,
  output logic [DW-1:0]     acc_o,
  output logic [AW-1:0]     ext_raddr,
  input  logic [DW-1:0]     ext_rdata,
  output logic [AW-1:0]     ext_waddr,
  input  logic [DW-1:0]     ext_wcur,
  output logic              ext_we,
  output logic [DW-1:0]     ext_wdata
);
  localparam int NLOC = 1 << AW;
  localparam logic [AW-1:0] A_WIN0 = AW'(0);
  localparam logic [AW-1:0] A_PTR0 = AW'(1);
  localparam logic [AW-1:0] A_WIN1 = AW'(2);
  localparam logic [AW-1:0] A_PTR1 = AW'(3);
  localparam logic [AW-1:0] A_ACC  = AW'(5);
  localparam logic [AW-1:0] A_RAM  = AW'(RAM_LO);
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_CLR = 2'd2;
  localparam logic [1:0] OP_SET = 2'd3;

  typedef enum logic [2:0] {K_NULL, K_RAM, K_MP0, K_MP1, K_ACC, K_EXT, K_RSV} kind_t;

  logic [AW-1:0] mp0, mp1;
  logic [DW-1:0] acc;
  logic [DW-1:0] ram [RAM_LO:NLOC-1];

  function automatic logic [AW-1:0] redirect(logic [AW-1:0] a, logic [AW-1:0] p0, logic [AW-1:0] p1);
    if (a == A_WIN0) return p0;
    if (a == A_WIN1) return p1;
    return a;
  endfunction

  function automatic kind_t classify(logic [AW-1:0] t);
    if (t == A_WIN0 || t == A_WIN1) return K_NULL;
    if (t >= A_RAM)  return K_RAM;
    if (t == A_PTR0) return K_MP0;
    if (t == A_PTR1) return K_MP1;
    if (t == A_ACC)  return K_ACC;
    if (EXT_MAP[t])  return K_EXT;
    return K_RSV;
  endfunction

  logic [AW-1:0] rt, wt;
  kind_t rk, wk;
  logic [DW-1:0] cur_val, new_val, mask;
  logic do_wr;

  assign rt = redirect(rd_addr, mp0, mp1);
  assign wt = redirect(wr_addr, mp0, mp1);
  assign rk = classify(rt);
  assign wk = classify(wt);
  assign do_wr = (wr_op != 2'd0);
  assign mask = DW'(1) << wr_bit;

  always_comb begin
    case (rk)
      K_RAM:   rd_data = ram[rt];
      K_MP0:   rd_data = DW'(mp0);
      K_MP1:   rd_data = DW'(mp1);
      K_ACC:   rd_data = acc;
      K_EXT:   rd_data = ext_rdata;
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    case (wk)
      K_RAM:   cur_val = ram[wt];
      K_MP0:   cur_val = DW'(mp0);
      K_MP1:   cur_val = DW'(mp1);
      K_ACC:   cur_val = acc;
      K_EXT:   cur_val = ext_wcur;
      default: cur_val = '0;
    endcase
  end

  always_comb begin
    case (wr_op)
      OP_WR:   new_val = wr_data;
      OP_CLR:  new_val = cur_val & ~mask;
      OP_SET:  new_val = cur_val | mask;
      default: new_val = cur_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp0 <= '0;
      mp1 <= '0;
      acc <= '0;
    end else if (do_wr) begin
      if (wk == K_MP0) mp0 <= new_val[AW-1:0];
      if (wk == K_MP1) mp1 <= new_val[AW-1:0];
      if (wk == K_ACC) acc <= new_val;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr && wk == K_RAM) ram[wt] <= new_val;
  end

  assign acc_o     = acc;
  assign ext_raddr = rt;
  assign ext_waddr = wt;
  assign ext_we    = do_wr && (wk == K_EXT);
  assign ext_wdata = new_val;
endmodule

module ptr_regfile_chk #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int RAM_LO = 'h28,
  parameter logic [(1<<AW)-1:0] EXT_MAP = 'h0F_03FC_FC00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     rd_addr,
  input logic [DW-1:0]     rd_data,
  input logic [1:0]        wr_op,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [$clog2(DW)-1:0] wr_bit,
  input logic [DW-1:0]     acc_o,
  input logic              ext_we,
  input logic [AW-1:0]     mp0,
  input logic [AW-1:0]     mp1
);
  logic rsv_direct;
  logic mp0_dead, mp1_dead;
  assign rsv_direct = (rd_addr == AW'(4)) ||
                      (rd_addr > AW'(5) && rd_addr < AW'(RAM_LO) && !EXT_MAP[rd_addr]);
  assign mp0_dead = (mp0 == AW'(0)) || (mp0 == AW'(2));
  assign mp1_dead = (mp1 == AW'(0)) || (mp1 == AW'(2));

  assert_ptr_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (acc_o == '0 && mp0 == '0 && mp1 == '0));

  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == 2'd1 && wr_addr == AW'(1)) |=> mp0 == $past(wr_data[AW-1:0]));

  assert_dead_window_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_addr == AW'(0) && mp0_dead) || (rd_addr == AW'(2) && mp1_dead)) |-> rd_data == '0);

  assert_dead_window_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_addr == AW'(0) && mp0_dead) || (wr_addr == AW'(2) && mp1_dead)) |-> !ext_we);

  assert_acc_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == 2'd1 && wr_addr == AW'(5)) |=> acc_o == $past(wr_data));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_direct |-> rd_data == '0);

  assert_ext_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> wr_op != 2'd0);

  assert_acc_bitset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == 2'd3 && wr_addr == AW'(5)) |=> acc_o[$past(wr_bit)] == 1'b1);
endmodule

bind ptr_regfile ptr_regfile_chk #(.AW(AW), .DW(DW), .RAM_LO(RAM_LO), .EXT_MAP(EXT_MAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data), .wr_bit(wr_bit),
  .acc_o(acc_o), .ext_we(ext_we), .mp0(mp0), .mp1(mp1)
);

// File: tb/tb_ptr_regfile.sv
module tb_ptr_regfile;
  localparam int CLK_P = 10;
  localparam logic [127:0] XMAP = 128'h0F_03FC_FC00;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] rd_addr = '0, wr_addr = '0;
  logic [7:0] rd_data, wr_data = '0, acc_o, ext_rdata, ext_wcur, ext_wdata;
  logic [1:0] wr_op = '0;
  logic [2:0] wr_bit = '0;
  logic [6:0] ext_raddr, ext_waddr;
  logic ext_we;

  logic [7:0] ext_mem [128];
  logic [7:0] m_ram [128];
  bit         m_known [128];
  logic [6:0] m_mp0, m_mp1;
  logic [7:0] m_acc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ptr_regfile dut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_op(wr_op), .wr_addr(wr_addr), .wr_data(wr_data), .wr_bit(wr_bit),
    .acc_o(acc_o), .ext_raddr(ext_raddr), .ext_rdata(ext_rdata),
    .ext_waddr(ext_waddr), .ext_wcur(ext_wcur), .ext_we(ext_we), .ext_wdata(ext_wdata)
  );

  assign ext_rdata = ext_mem[ext_raddr];
  assign ext_wcur  = ext_mem[ext_waddr];
  always @(posedge clk) if (ext_we) ext_mem[ext_waddr] <= ext_wdata;

  // kinds: 0 dead, 1 ram, 2 p0, 3 p1, 4 acc, 5 external, 6 reserved
  function automatic logic [6:0] redir(logic [6:0] a);
    if (a == 7'h00) return m_mp0;
    if (a == 7'h02) return m_mp1;
    return a;
  endfunction

  function automatic int kind(logic [6:0] t);
    if (t == 7'h00 || t == 7'h02) return 0;
    if (t >= 7'h28) return 1;
    if (t == 7'h01) return 2;
    if (t == 7'h03) return 3;
    if (t == 7'h05) return 4;
    if (XMAP[t]) return 5;
    return 6;
  endfunction

  function automatic logic [7:0] mval(logic [6:0] t, output bit kn);
    kn = 1;
    case (kind(t))
      1: begin kn = m_known[t]; return m_ram[t]; end
      2: return {1'b0, m_mp0};
      3: return {1'b0, m_mp1};
      4: return m_acc;
      5: return ext_mem[t];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rtag(logic [6:0] a);
    int k;
    k = kind(redir(a));
    if (k == 0) return "R5";
    if (a == 7'h00 || a == 7'h02) return "R4";
    case (k)
      1: return "R2";
      2, 3: return "R3";
      4: return "R6";
      5: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [1:0] op, logic [6:0] wa, logic [7:0] wd, logic [2:0] wb,
                     logic [6:0] ra, string tag);
    logic [6:0] t, wt;
    logic [7:0] ev, cur, nv;
    bit kn, wkn, xwe;
    int wk;
    string tg;
    @(negedge clk);
    wr_op = op; wr_addr = wa; wr_data = wd; wr_bit = wb; rd_addr = ra;
    #1;
    t = redir(ra);
    ev = mval(t, kn);
    tg = (tag != "") ? tag : rtag(ra);
    if (kn) chk(tg, rd_data, ev);
    chk("R6", acc_o, m_acc);
    wt = redir(wa);
    wk = kind(wt);
    cur = mval(wt, wkn);
    case (op)
      2'd1: nv = wd;
      2'd2: nv = cur & ~(8'h01 << wb);
      2'd3: nv = cur | (8'h01 << wb);
      default: nv = cur;
    endcase
    xwe = (op != 2'd0) && (wk == 5);
    chk("R8", {7'b0, ext_we}, {7'b0, xwe});
    if (xwe) begin
      chk("R8", {1'b0, ext_waddr}, {1'b0, wt});
      chk("R9", ext_wdata, nv);
    end
    @(posedge clk);
    if (op != 2'd0) begin
      case (wk)
        1: begin m_ram[wt] = nv; m_known[wt] = (op == 2'd1) || wkn; end
        2: m_mp0 = nv[6:0];
        3: m_mp1 = nv[6:0];
        4: m_acc = nv;
        default: ;
      endcase
    end
  endtask

  function automatic logic [6:0] pick_addr();
    case ($urandom % 8)
      0: return 7'h00;
      1: return 7'h02;
      2: return 7'h01;
      3: return 7'h03;
      4: return 7'h05;
      5: return 7'($urandom % 'h28);
      default: return 7'h28 + 7'($urandom % 88);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 128; i++) begin
      ext_mem[i] = 8'(i * 3 + 1);
      m_known[i] = 0;
      m_ram[i] = '0;
    end
    m_mp0 = '0; m_mp1 = '0; m_acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cyc(0, 0, 0, 0, 7'h01, "R1");
    cyc(0, 0, 0, 0, 7'h03, "R1");
    cyc(0, 0, 0, 0, 7'h05, "R1");
    chk("R1", acc_o, 8'h00);

    cyc(1, 7'h30, 8'hA5, 0, 7'h30, "R2");
    cyc(1, 7'h30, 8'h3C, 0, 7'h30, "R10");
    cyc(0, 0, 0, 0, 7'h30, "R10");
    cyc(1, 7'h7F, 8'h5D, 0, 7'h28, "R2");
    cyc(0, 0, 0, 0, 7'h7F, "R2");

    cyc(1, 7'h01, 8'hFF, 0, 7'h01, "R3");
    cyc(0, 0, 0, 0, 7'h01, "R3");
    cyc(1, 7'h03, 8'hAB, 0, 7'h03, "R3");
    cyc(0, 0, 0, 0, 7'h03, "R3");

    cyc(1, 7'h01, 8'h30, 0, 7'h01, "R3");
    cyc(0, 0, 0, 0, 7'h00, "R4");
    cyc(1, 7'h00, 8'h77, 0, 7'h00, "R4");
    cyc(0, 0, 0, 0, 7'h30, "R4");
    cyc(1, 7'h03, 8'h7F, 0, 7'h02, "R4");
    cyc(1, 7'h02, 8'h11, 0, 7'h02, "R4");
    cyc(0, 0, 0, 0, 7'h7F, "R4");

    cyc(1, 7'h01, 8'h02, 0, 7'h00, "R4");
    cyc(0, 0, 0, 0, 7'h00, "R5");
    cyc(1, 7'h00, 8'h99, 0, 7'h03, "R5");
    cyc(3, 7'h00, 8'h00, 6, 7'h03, "R5");
    cyc(0, 0, 0, 0, 7'h7F, "R5");
    cyc(1, 7'h01, 8'h00, 0, 7'h00, "R5");
    cyc(1, 7'h00, 8'h44, 0, 7'h00, "R5");
    cyc(0, 0, 0, 0, 7'h01, "R5");

    cyc(1, 7'h05, 8'hC3, 0, 7'h05, "R6");
    cyc(0, 0, 0, 0, 7'h05, "R6");

    cyc(1, 7'h04, 8'h55, 0, 7'h04, "R7");
    cyc(0, 0, 0, 0, 7'h04, "R7");
    cyc(1, 7'h26, 8'hAA, 0, 7'h26, "R7");
    cyc(0, 0, 0, 0, 7'h26, "R7");

    cyc(1, 7'h0A, 8'h5A, 0, 7'h0A, "R8");
    cyc(0, 0, 0, 0, 7'h0A, "R8");
    cyc(1, 7'h03, 8'h21, 0, 7'h02, "R8");
    cyc(1, 7'h02, 8'h6E, 0, 7'h02, "R8");
    cyc(0, 0, 0, 0, 7'h21, "R8");

    cyc(3, 7'h30, 8'h00, 7, 7'h30, "R9");
    cyc(0, 0, 0, 0, 7'h30, "R9");
    cyc(2, 7'h05, 8'h00, 0, 7'h05, "R9");
    cyc(0, 0, 0, 0, 7'h05, "R9");
    cyc(1, 7'h01, 8'h30, 0, 7'h01, "R9");
    cyc(2, 7'h00, 8'h00, 1, 7'h30, "R9");
    cyc(0, 0, 0, 0, 7'h30, "R9");
    cyc(3, 7'h0B, 8'h00, 4, 7'h0B, "R9");
    cyc(0, 0, 0, 0, 7'h0B, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [6:0] wa;
      logic [7:0] wd;
      wa = pick_addr();
      wd = 8'($urandom);
      if (wa == 7'h01 || wa == 7'h03)
        case ($urandom % 4)
          0: wd = 8'h00;
          1: wd = 8'h02;
          default: wd = 8'h28 + 8'($urandom % 88);
        endcase
      cyc(2'($urandom), wa, wd, 3'($urandom), pick_addr(), "");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule